// File: doc/BRIEF.md
# Cuckoo Hash Exact-Match Lookup Engine

This block answers exact-match queries on a small, changing set of keys. One search key may be presented on every clock cycle. One cycle later the block reports whether the key is held and, if so, the data stored with it. The key set lives in NTAB small tables of 2^IDX_W records each. Every table has its own CRC-8 hash of the key: table 0 uses polynomial 0x07, table 1 uses 0x1D, and the low IDX_W bits of the remainder form the index. One extra parking register holds a record while it moves between tables. For each query, the records the key could occupy in every table are read at once, together with the parking register, and all are compared with the key in the same cycle.

A separate configuration port inserts and deletes keys. An insert whose slots are all taken pushes the resident record of table 0 into the parking register. That record then goes to its slot in the next table, and the chain continues the same way, one displacement per cycle, while lookups carry on. Every active key stays findable at every cycle. After MAX_KICKS displacements the chain stops. The record still parked stays there and stays searchable, and the full flag rises.

Top module: `cuckoo_lookup`

## Requirements
- R1: A lookup presented with `lk_valid` high gives its result in the next cycle. In a cycle after one without a request, `res_invalid` is 1, `res_found` is 0 and `res_data` is 0.
- R2: A key whose insert is accepted at a clock edge is reported found with its data by every lookup issued from that edge on, until it is deleted.
- R3: At most one of the candidate records (the table slots plus the parking register) matches a key. The reported data is that record's data.
- R4: Inserting a key that is already held replaces its data, completes in the cycle it is accepted, and leaves `cfg_ready` high.
- R5: Deleting an absent key changes nothing. Deleting a held key makes lookups issued from the next cycle report it as not found.
- R6: While a relocation chain runs, `cfg_ready` is 0. Lookups still report every active key, including the one being moved.
- R7: After MAX_KICKS displacements the chain stops and `ins_full` rises. With default parameters this happens no later than the insert of the 33rd distinct key. All keys inserted before that point remain found.
- R8: While `ins_full` is 1, inserting a new key is accepted in one cycle and discarded. Deleting every held key clears `ins_full`.
- R9: After reset no key is held, `res_invalid` is 1, `cfg_ready` is 1 and `ins_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A search key is present this cycle |
| lk_key | input | KEY_W | Search key |
| res_invalid | output | 1 | The result slot holds no lookup |
| res_found | output | 1 | Searched key is held |
| res_data | output | DATA_W | Data of the matching record, 0 if none |
| cfg_valid | input | 1 | Configuration request present |
| cfg_insert | input | 1 | 1 for insert, 0 for delete |
| cfg_key | input | KEY_W | Key to insert or delete |
| cfg_data | input | DATA_W | Data for an insert |
| cfg_ready | output | 1 | A request is accepted this cycle |
| ins_full | output | 1 | Last insertion gave up; a record is stranded in the parking register |

## Verification
The bench keeps a plain set of keys and streams random lookups every cycle, so each result is checked against the set. This catches a relocation that drops a key for a single cycle, and a design that updated its tables before the parking register would show it as a lone miss during a chain. Directed sequences check overwrite of a held key, which a wrong design would store twice and report with corrupt data. They also check deletion of an absent key, which must leave its neighbours intact. Finally the bench fills the tables until `ins_full` rises, then checks that the stranded key stays findable, that new inserts are dropped, and that the flag clears once every key is gone.

// File: rtl/ck_pkg.sv
package ck_pkg;
    parameter int KEY_W  = 8;
    parameter int DATA_W = 8;

    typedef struct packed {
        logic              valid;
        logic [KEY_W-1:0]  key;
        logic [DATA_W-1:0] data;
    } rec_t;

    typedef enum logic {CTL_IDLE, CTL_KICK} ctl_state_e;

    // one generator polynomial per table
    function automatic logic [7:0] poly_of(input int tab);
        case (tab)
            0:       return 8'h07;
            1:       return 8'h1D;
            2:       return 8'h31;
            default: return 8'h9B;
        endcase
    endfunction

    // bit-serial CRC-8 of the key, MSB first, zero initial value
    function automatic logic [7:0] crc8(input logic [KEY_W-1:0] key, input logic [7:0] poly);
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = KEY_W - 1; i >= 0; i--) begin
            fb = c[7] ^ key[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction
endpackage

// File: rtl/ck_hash.sv
module ck_hash
    import ck_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAB   = 0
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    logic [7:0] rem;
    assign rem = crc8(key, poly_of(TAB));
    assign idx = rem[IDX_W-1:0];
endmodule

// File: rtl/ck_table.sv
module ck_table
    import ck_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx_a,
    output rec_t             rd_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output rec_t             rd_b,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  rec_t             wr_rec
);
    localparam int DEPTH = 1 << IDX_W;

    rec_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_rec;
        end
    end

    assign rd_a = mem[rd_idx_a];
    assign rd_b = mem[rd_idx_b];
endmodule

// File: rtl/ck_match.sv
module ck_match
    import ck_pkg::*;
#(
    parameter int NCAND = 3
) (
    input  logic [KEY_W-1:0]  key,
    input  rec_t [NCAND-1:0]  cand,
    output logic              found,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        found = 1'b0;
        data  = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (cand[i].valid && cand[i].key == key) begin
                found = 1'b1;
                data  = data | cand[i].data;
            end
        end
    end
endmodule

// File: rtl/ck_ctrl.sv
module ck_ctrl
    import ck_pkg::*;
#(
    parameter int NTAB      = 2,
    parameter int MAX_KICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_insert,
    input  logic [KEY_W-1:0]  cfg_key,
    input  logic [DATA_W-1:0] cfg_data,
    input  rec_t [NTAB-1:0]   slot,
    output logic [KEY_W-1:0]  cur_key,
    output logic [NTAB-1:0]   we,
    output rec_t              wr_rec,
    output rec_t              park,
    output logic              ready,
    output logic              full
);
    localparam int KCNT_W = $clog2(MAX_KICKS + 1);
    localparam int TAB_W  = (NTAB > 1) ? $clog2(NTAB) : 1;

    ctl_state_e        state, state_n;
    logic [TAB_W-1:0]  tgt, tgt_n, free_idx;
    logic [KCNT_W-1:0] kicks, kicks_n;
    rec_t              park_n, fresh;
    logic              full_n, have_free, park_hit;
    logic [NTAB-1:0]   hit;

    function automatic logic [TAB_W-1:0] next_tab(input logic [TAB_W-1:0] t);
        return (t == TAB_W'(NTAB - 1)) ? '0 : t + 1'b1;
    endfunction

    assign cur_key  = (state == CTL_KICK) ? park.key : cfg_key;
    assign ready    = (state == CTL_IDLE);
    assign fresh    = rec_t'{1'b1, cfg_key, cfg_data};
    assign park_hit = park.valid && park.key == cfg_key;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = NTAB - 1; i >= 0; i--) begin
            hit[i] = slot[i].valid && slot[i].key == cfg_key;
            if (!slot[i].valid) begin
                have_free = 1'b1;
                free_idx  = TAB_W'(i);
            end
        end
    end

    always_comb begin
        state_n = state;
        tgt_n   = tgt;
        kicks_n = kicks;
        park_n  = park;
        full_n  = full;
        we      = '0;
        wr_rec  = '0;
        case (state)
            CTL_IDLE: begin
                if (cfg_valid) begin
                    if (!cfg_insert) begin
                        we = hit;
                        if (park_hit) begin
                            park_n = '0;
                            full_n = 1'b0;
                        end
                    end else if ((|hit) || park_hit) begin
                        we     = hit;
                        wr_rec = fresh;
                        if (park_hit) park_n.data = cfg_data;
                    end else if (!full) begin
                        wr_rec = fresh;
                        if (have_free) begin
                            we[free_idx] = 1'b1;
                        end else begin
                            we[0]   = 1'b1;
                            park_n  = slot[0];
                            tgt_n   = next_tab('0);
                            kicks_n = KCNT_W'(1);
                            state_n = CTL_KICK;
                        end
                    end
                end
            end
            CTL_KICK: begin
                if (!slot[tgt].valid) begin
                    we[tgt] = 1'b1;
                    wr_rec  = park;
                    park_n  = '0;
                    state_n = CTL_IDLE;
                end else if (kicks == KCNT_W'(MAX_KICKS)) begin
                    full_n  = 1'b1;
                    state_n = CTL_IDLE;
                end else begin
                    we[tgt] = 1'b1;
                    wr_rec  = park;
                    park_n  = slot[tgt];
                    tgt_n   = next_tab(tgt);
                    kicks_n = kicks + 1'b1;
                end
            end
            default: state_n = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CTL_IDLE;
            tgt   <= '0;
            kicks <= '0;
            park  <= '0;
            full  <= 1'b0;
        end else begin
            state <= state_n;
            tgt   <= tgt_n;
            kicks <= kicks_n;
            park  <= park_n;
            full  <= full_n;
        end
    end
endmodule

// File: rtl/cuckoo_lookup.sv
module cuckoo_lookup
    import ck_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int NTAB      = 2,
    parameter int MAX_KICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              res_invalid,
    output logic              res_found,
    output logic [DATA_W-1:0] res_data,
    input  logic              cfg_valid,
    input  logic              cfg_insert,
    input  logic [KEY_W-1:0]  cfg_key,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              cfg_ready,
    output logic              ins_full
);
    logic [NTAB-1:0][IDX_W-1:0] lk_idx, ct_idx;
    rec_t [NTAB-1:0]            lk_rec, ct_rec;
    rec_t [NTAB:0]              cand;
    logic [NTAB-1:0]            we;
    rec_t                       wr_rec, park;
    logic [KEY_W-1:0]           cur_key;
    logic                       hit_any;
    logic [DATA_W-1:0]          hit_data;

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        ck_hash #(.IDX_W(IDX_W), .TAB(t)) u_hash_lk (.key(lk_key),  .idx(lk_idx[t]));
        ck_hash #(.IDX_W(IDX_W), .TAB(t)) u_hash_ct (.key(cur_key), .idx(ct_idx[t]));
        ck_table #(.IDX_W(IDX_W)) u_table (
            .clk(clk), .rst(rst),
            .rd_idx_a(lk_idx[t]), .rd_a(lk_rec[t]),
            .rd_idx_b(ct_idx[t]), .rd_b(ct_rec[t]),
            .we(we[t]), .wr_idx(ct_idx[t]), .wr_rec(wr_rec)
        );
        assign cand[t] = lk_rec[t];
    end
    assign cand[NTAB] = park;

    ck_match #(.NCAND(NTAB + 1)) u_match (
        .key(lk_key), .cand(cand), .found(hit_any), .data(hit_data)
    );

    ck_ctrl #(.NTAB(NTAB), .MAX_KICKS(MAX_KICKS)) u_ctrl (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_insert(cfg_insert),
        .cfg_key(cfg_key), .cfg_data(cfg_data),
        .slot(ct_rec), .cur_key(cur_key), .we(we), .wr_rec(wr_rec),
        .park(park), .ready(cfg_ready), .full(ins_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_invalid <= 1'b1;
            res_found   <= 1'b0;
            res_data    <= '0;
        end else begin
            res_invalid <= !lk_valid;
            res_found   <= lk_valid && hit_any;
            res_data    <= (lk_valid && hit_any) ? hit_data : '0;
        end
    end
endmodule

// File: rtl/ck_checker.sv
module ck_checker
    import ck_pkg::*;
#(
    parameter int NTAB = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [KEY_W-1:0]  lk_key,
    input logic              res_invalid,
    input logic              res_found,
    input logic [DATA_W-1:0] res_data,
    input logic              cfg_valid,
    input logic              cfg_insert,
    input logic              cfg_ready,
    input logic              ins_full,
    input rec_t [NTAB:0]     cand
);
    logic [NTAB:0] cand_hit;
    always_comb begin
        for (int i = 0; i <= NTAB; i++)
            cand_hit[i] = cand[i].valid && cand[i].key == lk_key;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> !res_invalid);
    assert_idle_slot_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (res_invalid && !res_found && res_data == '0));
    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cand_hit));
    assert_delete_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_ready && !cfg_insert) |=> cfg_ready);
    assert_chain_not_full_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_ready |-> !ins_full);
    assert_full_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (ins_full && cfg_valid && cfg_ready) |=> cfg_ready);
endmodule

bind cuckoo_lookup ck_checker #(.NTAB(NTAB)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_key(lk_key),
    .res_invalid(res_invalid), .res_found(res_found), .res_data(res_data),
    .cfg_valid(cfg_valid), .cfg_insert(cfg_insert), .cfg_ready(cfg_ready),
    .ins_full(ins_full), .cand(cand)
);

// File: tb/cuckoo_lookup_tb.sv
`timescale 1ns/1ps
module cuckoo_lookup_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lk_valid = 1'b0;
    logic [7:0] lk_key = '0;
    logic       res_invalid, res_found;
    logic [7:0] res_data;
    logic       cfg_valid = 1'b0, cfg_insert = 1'b0;
    logic [7:0] cfg_key = '0, cfg_data = '0;
    logic       cfg_ready, ins_full;

    cuckoo_lookup u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_key(lk_key),
        .res_invalid(res_invalid), .res_found(res_found), .res_data(res_data),
        .cfg_valid(cfg_valid), .cfg_insert(cfg_insert), .cfg_key(cfg_key),
        .cfg_data(cfg_data), .cfg_ready(cfg_ready), .ins_full(ins_full)
    );

    always #2 clk = ~clk;

    int   total = 0, bad = 0, busy_cycles = 0;
    bit   present [256];
    logic [7:0] mdata [256];
    bit   rdy_s = 1'b1, full_s = 1'b0, auto_lk = 1'b1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock: model update at the edge, compare after it, drive next inputs
    task automatic tick();
        bit e_inv, e_found, rdy_pre;
        logic [7:0] e_data;
        string tg;
        @(posedge clk);
        rdy_pre = rdy_s;
        e_inv   = !lk_valid;
        e_found = lk_valid && present[lk_key];
        e_data  = e_found ? mdata[lk_key] : 8'h00;
        if (cfg_valid && rdy_pre) begin
            if (!cfg_insert) present[cfg_key] = 1'b0;
            else if (present[cfg_key]) mdata[cfg_key] = cfg_data;
            else if (!full_s) begin
                present[cfg_key] = 1'b1;
                mdata[cfg_key]   = cfg_data;
            end
        end
        if (!rdy_pre) busy_cycles++;
        @(negedge clk);
        tg = e_inv ? "R1" : (!rdy_pre ? "R6" : (e_found ? "R2" : "R5"));
        chk(res_invalid == e_inv, tg, "res_invalid", res_invalid, e_inv);
        chk(res_found == e_found, tg, "res_found", res_found, e_found);
        chk(res_data == e_data, tg, "res_data", res_data, e_data);
        rdy_s  = cfg_ready;
        full_s = ins_full;
        if (auto_lk) begin
            lk_valid = ($urandom_range(3, 0) != 0);
            lk_key   = 8'($urandom_range(47, 0));
        end
    endtask

    task automatic cfg_op(input bit ins, input logic [7:0] k, input logic [7:0] d);
        while (!rdy_s) tick();
        cfg_valid = 1'b1; cfg_insert = ins; cfg_key = k; cfg_data = d;
        tick();
        cfg_valid = 1'b0;
    endtask

    task automatic probe(input logic [7:0] k, input bit ef, input logic [7:0] ed, input string tag);
        auto_lk  = 1'b0;
        lk_valid = 1'b1;
        lk_key   = k;
        tick();
        chk(res_found == ef, tag, "probe found", res_found, ef);
        chk(res_data == (ef ? ed : 8'h00), tag, "probe data", res_data, ef ? ed : 8'h00);
        auto_lk = 1'b1;
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) begin present[i] = 1'b0; mdata[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(res_invalid == 1'b1, "R9", "res_invalid", res_invalid, 1);
        chk(res_found == 1'b0, "R9", "res_found", res_found, 0);
        chk(cfg_ready == 1'b1, "R9", "cfg_ready", cfg_ready, 1);
        chk(ins_full == 1'b0, "R9", "ins_full", ins_full, 0);
        rdy_s = cfg_ready; full_s = ins_full;
        probe(8'd20, 1'b0, 8'h00, "R9");

        // R2: inserts become visible next cycle
        cfg_op(1'b1, 8'd10, 8'h11);
        cfg_op(1'b1, 8'd20, 8'h22);
        cfg_op(1'b1, 8'd30, 8'h33);
        probe(8'd20, 1'b1, 8'h22, "R2");
        probe(8'd10, 1'b1, 8'h11, "R2");

        // R4: overwrite in one cycle
        cfg_op(1'b1, 8'd20, 8'h44);
        chk(rdy_s == 1'b1, "R4", "ready after overwrite", rdy_s, 1);
        probe(8'd20, 1'b1, 8'h44, "R4");

        // R5: delete absent, then present
        cfg_op(1'b0, 8'd99, 8'h00);
        probe(8'd10, 1'b1, 8'h11, "R5");
        probe(8'd30, 1'b1, 8'h33, "R5");
        cfg_op(1'b0, 8'd10, 8'h00);
        probe(8'd10, 1'b0, 8'h00, "R5");

        // mixed traffic with lookups every cycle
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(2, 0) == 0)
                cfg_op($urandom_range(2, 0) != 0, 8'($urandom_range(47, 0)), 8'($urandom));
            else tick();
        end
        for (int k = 0; k < 48; k++) cfg_op(1'b0, 8'(k), 8'h00);
        while (!rdy_s) tick();
        chk(full_s == 1'b0, "R8", "full after clearing", full_s, 0);

        // R7: fill until the chain gives up
        n = 0;
        for (int k = 1; k <= 40; k++) begin
            while (!rdy_s) tick();
            if (full_s) break;
            cfg_op(1'b1, 8'(k), 8'(k) ^ 8'hA5);
            n = k;
        end
        while (!rdy_s) tick();
        chk(full_s == 1'b1, "R7", "ins_full", full_s, 1);
        chk(n <= 33, "R7", "inserts before full", n, 33);
        chk(busy_cycles > 0, "R6", "relocation cycles seen", busy_cycles, 1);
        for (int k = 1; k <= n; k++) probe(8'(k), 1'b1, 8'(k) ^ 8'hA5, "R7");

        // R8: new key dropped while full
        cfg_op(1'b1, 8'd200, 8'h5A);
        chk(rdy_s == 1'b1, "R8", "ready after dropped insert", rdy_s, 1);
        probe(8'd200, 1'b0, 8'h00, "R8");
        chk(full_s == 1'b1, "R8", "full held", full_s, 1);
        cfg_op(1'b1, 8'd1, 8'h3C);
        probe(8'd1, 1'b1, 8'h3C, "R4");

        for (int k = 1; k <= n; k++) cfg_op(1'b0, 8'(k), 8'h00);
        while (!rdy_s) tick();
        chk(full_s == 1'b0, "R8", "full cleared", full_s, 0);
        probe(8'd5, 1'b0, 8'h00, "R5");
        repeat (20) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule